// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast and Normal Outputs

This controller gathers sixty-four interrupt sources, split into two 32-bit banks, behind a simple 32-bit register bus. A rising edge on a source latches a pending bit. That bit stays set until software writes a one to it. Each source has its own enable bit and a 3-bit priority. The priority does two jobs: it chooses which of the two processor-facing outputs the source drives, and it ranks the source against the others on that output.

Priority values 0 and 1 send a source to the fast output, and values 2 through 7 send it to the normal output. Among the pending, enabled sources on each output, the controller registers a winner: the lowest priority value wins, and on a tie the lower source index wins. The winner is reported as an entry address, which is a programmable base plus four times the winner's index plus one. The normal winner's entry address is also driven on a dedicated output port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source's pending bit is set only by a low-to-high transition of its input. A source held high after its bit is cleared does not set it again until it falls and rises once more.
- R2: A pending bit stays set until it is cleared by writing a one to its position in either bank status word. Source index i uses bank i/32 and bit i%32. Writing a zero leaves the bit unchanged, and an all-ones write clears the whole bank.
- R3: The enable words (offset 0x18 for sources 0-31, 0x1C for 32-63) reset to 0. A source whose enable bit is 0 drives neither output and takes no part in either winner. Pending status is kept while the source is disabled.
- R4: The eight priority words at 0x30 + 4*k each hold sources 8k to 8k+7, one per 4-bit nibble, with the lowest source in bits 3:0. Only the low 3 bits of a nibble are stored, and the top bit of each nibble reads 0. Every priority resets to 7, so each word reads 0x77777777.
- R5: A source with priority 0 or 1 is routed to the fast output, and one with priority 2 to 7 is routed to the normal output. The fast status words at 0x00/0x04 read the pending bits of fast-routed sources. The normal status words at 0x08/0x0C read the pending bits of normal-routed sources.
- R6: On each output, the winner is the pending, enabled source with the numerically lowest priority. A tie goes to the lower index.
- R7: The entry words at 0x10 (fast) and 0x14 (normal) read base + 4*(index+1) of their winner, or 0 when there is no winner. The norm_entry_o port always equals the 0x14 value.
- R8: The entry base word at 0x24 resets to 0 and reads back the full 32-bit value last written.
- R9: The control word at 0x20 resets to 0, stores its bit 0, and reads the other bits as 0. Disabling a source always takes effect at the next output update.
- R10: The outputs, the winners and the entry values are registered. They reflect a status, enable or priority change one clock edge after the edge that applied it.
- R11: Reading an offset not listed above returns 0. Writing to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 64 | Interrupt source inputs, captured on rising edge |
| bus_wr_i | input | 1 | Write strobe, one write per clock while high |
| bus_addr_i | input | 8 | Byte offset of the register accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational from registers |
| fast_irq_o | output | 1 | Fast interrupt request |
| norm_irq_o | output | 1 | Normal interrupt request |
| norm_entry_o | output | 32 | Entry address of the current normal winner, 0 when none |

## Verification
Some properties are checked by assertions on every cycle. A pending bit never drops without a clear write, and a captured edge always sets its bit. Neither output rises unless an enabled source was pending on the cycle before, and the fast output needs an enabled pending source at priority 0 or 1. A registered normal winner was a real candidate, and the normal entry port is zero whenever the normal output is low. Other behaviour only the bench scenarios can show. These include tie-breaking by index, lower values beating higher ones, the nibble layout and dropped top bit, the one-edge output latency, the rule that a held input does not re-arm, and the rule that unmapped writes leave all state alone.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DW        = 32;
  localparam int SRC_PER_W = 8;
  localparam int NIB_W     = 4;
  localparam int FAST_LIM  = 2;

  localparam int OFS_FST   = 'h00;
  localparam int OFS_NRM   = 'h08;
  localparam int OFS_FENT  = 'h10;
  localparam int OFS_NENT  = 'h14;
  localparam int OFS_EN    = 'h18;
  localparam int OFS_CTL   = 'h20;
  localparam int OFS_BASE  = 'h24;
  localparam int OFS_PRI   = 'h30;
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] src_q, pend_q, pend_d, rise;
  logic         armed_q;

  always_comb begin
    rise   = src_i & ~src_q;
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      pend_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      src_q   <= src_i;
      pend_q  <= pend_d;
      armed_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R2: a set bit survives unless its clear bit was written
  assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> &(~$past(pend_q) | $past(clr_i) | pend_q));

  // R1: an input edge seen on the previous clock leaves the bit set
  assert_edge_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> &(~($past(src_i) & ~$past(src_q)) | pend_q));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N  = 64,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  logic [PW-1:0] best;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i*PW +: PW] < best)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        best    = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int PW     = 3,
  parameter int CTRL_W = 1,
  parameter int AW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            fast_irq_o,
  output logic            norm_irq_o,
  output logic [DW-1:0]   norm_entry_o
);
  localparam int NBANK = NSRC / DW;
  localparam int NPRI  = NSRC / SRC_PER_W;
  localparam int IW    = $clog2(NSRC);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic [NSRC-1:0]    en_q, en_d, pend, clr, fast_sel, live, f_cand, n_cand;
  logic [PW-1:0]      prio_q [NSRC];
  logic [PW-1:0]      prio_d [NSRC];
  logic [NSRC*PW-1:0] prio_flat;
  logic [CTRL_W-1:0]  ctl_q, ctl_d;
  logic [DW-1:0]      base_q, base_d;
  logic               f_vld, n_vld, f_vld_q, n_vld_q, fast_q, norm_q;
  logic [IW-1:0]      f_idx, n_idx, f_idx_q, n_idx_q;
  logic [DW-1:0]      f_ent, n_ent;

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  // pending capture, one bank per 32 sources
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pic_src_bank #(.W(DW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .src_i  (src_i[b*DW +: DW]),
      .clr_i  (clr[b*DW +: DW]),
      .pend_o (pend[b*DW +: DW])
    );
  end

  // write decode and next state
  always_comb begin
    en_d   = en_q;
    ctl_d  = ctl_q;
    base_d = base_q;
    clr    = '0;
    for (int i = 0; i < NSRC; i++) prio_d[i] = prio_q[i];
    if (bus_wr_i) begin
      for (int b = 0; b < NBANK; b++) begin
        if (hit(bus_addr_i, OFS_FST + 4*b) || hit(bus_addr_i, OFS_NRM + 4*b))
          clr[b*DW +: DW] = bus_wdata_i;
        if (hit(bus_addr_i, OFS_EN + 4*b))
          en_d[b*DW +: DW] = bus_wdata_i;
      end
      for (int r = 0; r < NPRI; r++) begin
        if (hit(bus_addr_i, OFS_PRI + 4*r)) begin
          for (int n = 0; n < SRC_PER_W; n++)
            prio_d[r*SRC_PER_W + n] = bus_wdata_i[n*NIB_W +: PW];
        end
      end
      if (hit(bus_addr_i, OFS_CTL))  ctl_d  = bus_wdata_i[CTRL_W-1:0];
      if (hit(bus_addr_i, OFS_BASE)) base_d = bus_wdata_i;
    end
  end

  // routing and candidates
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      fast_sel[i]              = int'(prio_q[i]) < FAST_LIM;
      prio_flat[i*PW +: PW]    = prio_q[i];
    end
    live   = pend & en_q;
    f_cand = live & fast_sel;
    n_cand = live & ~fast_sel;
  end

  pic_arbiter #(.N(NSRC), .PW(PW)) u_arb_fast (
    .cand_i (f_cand), .prio_i (prio_flat), .valid_o (f_vld), .idx_o (f_idx)
  );
  pic_arbiter #(.N(NSRC), .PW(PW)) u_arb_norm (
    .cand_i (n_cand), .prio_i (prio_flat), .valid_o (n_vld), .idx_o (n_idx)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q    <= '0;
      ctl_q   <= '0;
      base_q  <= '0;
      fast_q  <= 1'b0;
      norm_q  <= 1'b0;
      f_vld_q <= 1'b0;
      n_vld_q <= 1'b0;
      f_idx_q <= '0;
      n_idx_q <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '1;
    end else begin
      en_q    <= en_d;
      ctl_q   <= ctl_d;
      base_q  <= base_d;
      fast_q  <= |f_cand;
      norm_q  <= |n_cand;
      f_vld_q <= f_vld;
      n_vld_q <= n_vld;
      f_idx_q <= f_idx;
      n_idx_q <= n_idx;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= prio_d[i];
    end
  end

  // entry values and read mux
  always_comb begin
    f_ent = f_vld_q ? base_q + ((DW'(f_idx_q) + 1) << 2) : '0;
    n_ent = n_vld_q ? base_q + ((DW'(n_idx_q) + 1) << 2) : '0;
    bus_rdata_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit(bus_addr_i, OFS_FST + 4*b))
        bus_rdata_o = pend[b*DW +: DW] & fast_sel[b*DW +: DW];
      if (hit(bus_addr_i, OFS_NRM + 4*b))
        bus_rdata_o = pend[b*DW +: DW] & ~fast_sel[b*DW +: DW];
      if (hit(bus_addr_i, OFS_EN + 4*b))
        bus_rdata_o = en_q[b*DW +: DW];
    end
    for (int r = 0; r < NPRI; r++) begin
      if (hit(bus_addr_i, OFS_PRI + 4*r)) begin
        for (int n = 0; n < SRC_PER_W; n++)
          bus_rdata_o[n*NIB_W +: NIB_W] = NIB_W'(prio_q[r*SRC_PER_W + n]);
      end
    end
    if (hit(bus_addr_i, OFS_FENT)) bus_rdata_o = f_ent;
    if (hit(bus_addr_i, OFS_NENT)) bus_rdata_o = n_ent;
    if (hit(bus_addr_i, OFS_CTL))  bus_rdata_o = DW'(ctl_q);
    if (hit(bus_addr_i, OFS_BASE)) bus_rdata_o = base_q;
  end

  assign fast_irq_o   = fast_q;
  assign norm_irq_o   = norm_q;
  assign norm_entry_o = n_ent;

  // R3: an output only rises from a source that was pending and enabled
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fast_irq_o || norm_irq_o) |-> $past(|(pend & en_q)));

  // R5: fast output requires an enabled pending source at priority 0 or 1
  assert_fast_route_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    fast_irq_o |-> $past(|(pend & en_q & fast_sel)));

  // R6: the registered normal winner was a candidate on the prior cycle
  assert_winner_cand_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    n_vld_q |-> ((($past(n_cand) >> n_idx_q) & NSRC'(1)) != '0));

  // R7: the normal entry port is zero whenever no normal request is raised
  assert_entry_idle_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !norm_irq_o |-> (norm_entry_o == '0));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        fast_irq, norm_irq;
  logic [31:0] norm_entry;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .src_i (src),
    .bus_wr_i (bus_wr), .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata), .fast_irq_o (fast_irq), .norm_irq_o (norm_irq),
    .norm_entry_o (norm_entry)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 fast out, 2 normal out, 3 entry port
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done     = 0;

  function automatic void compare(logic [31:0] got, logic [31:0] exp, string tag);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endfunction

  function automatic logic [31:0] observe(int kind);
    case (kind)
      1:       return 32'(fast_irq);
      2:       return 32'(norm_irq);
      3:       return norm_entry;
      default: return bus_rdata;
    endcase
  endfunction

  // monitor: compare queued expectations after the edge that follows them
  always @(posedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      compare(observe(e.kind), e.exp, e.tag);
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a;
    e.kind = 0; e.exp = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic expect_out(input int kind, input logic [31:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    e.kind = kind; e.exp = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    src[i] = 1'b1;
    @(negedge clk);
    src[i] = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] ent(logic [31:0] base, int idx);
    return base + 32'((idx + 1) * 4);
  endfunction

  task automatic report();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // reset state
    expect_rd(8'h18, 32'h0, "R3 enable bank0 reset");
    expect_rd(8'h1C, 32'h0, "R3 enable bank1 reset");
    expect_rd(8'h30, 32'h77777777, "R4 priority word0 reset");
    expect_rd(8'h4C, 32'h77777777, "R4 priority word7 reset");
    expect_rd(8'h24, 32'h0, "R8 base reset");
    expect_rd(8'h20, 32'h0, "R9 control reset");
    expect_rd(8'h10, 32'h0, "R7 fast entry idle");
    expect_rd(8'h14, 32'h0, "R7 normal entry idle");
    expect_out(1, 0, "R3 fast out reset");
    expect_out(2, 0, "R3 normal out reset");

    // disabled pending source
    pulse(5); settle();
    expect_rd(8'h08, 32'h20, "R2 normal status src5");
    expect_rd(8'h00, 32'h0, "R5 fast status empty");
    expect_out(2, 0, "R3 disabled source quiet");

    // enable and one-edge latency
    wr(8'h18, 32'h20);
    compare(32'(norm_irq), 0, "R10 output not yet updated");
    @(negedge clk);
    compare(32'(norm_irq), 1, "R10 output after one edge");
    settle();
    expect_rd(8'h14, ent(0, 5), "R7 normal entry src5");
    expect_out(3, ent(0, 5), "R7 entry port src5");

    // entry base
    wr(8'h24, 32'h1000); settle();
    expect_rd(8'h24, 32'h1000, "R8 base readback");
    expect_rd(8'h14, ent(32'h1000, 5), "R7 entry with base");

    // second bank, tie and priority win
    pulse(40); wr(8'h1C, 32'h100); settle();
    expect_rd(8'h0C, 32'h100, "R2 bank1 bit8 for src40");
    expect_rd(8'h14, ent(32'h1000, 5), "R6 tie lower index");
    wr(8'h44, 32'h77777773); settle();
    expect_rd(8'h44, 32'h77777773, "R4 priority word5 readback");
    expect_rd(8'h14, ent(32'h1000, 40), "R6 lower value wins");

    // reroute src5 to fast
    wr(8'h30, 32'h77177777); settle();
    expect_out(1, 1, "R5 fast out raised");
    expect_rd(8'h00, 32'h20, "R5 fast status src5");
    expect_rd(8'h08, 32'h0, "R5 normal status moved");
    expect_rd(8'h10, ent(32'h1000, 5), "R7 fast entry src5");
    expect_rd(8'h14, ent(32'h1000, 40), "R7 normal entry src40");

    // nibble top bit dropped
    wr(8'h44, 32'h8888888B); settle();
    expect_rd(8'h44, 32'h00000003, "R4 nibble top bit dropped");

    // write-zero and write-one clear
    wr(8'h0C, 32'h0); settle();
    expect_rd(8'h0C, 32'h100, "R2 zero write keeps bit");
    wr(8'h0C, 32'h100); settle();
    expect_rd(8'h0C, 32'h0, "R2 write one clears");
    expect_out(2, 0, "R2 normal out drops");
    expect_rd(8'h14, 32'h0, "R7 normal entry zero");
    expect_out(3, 32'h0, "R7 entry port zero");

    // fast winner ordering
    wr(8'h30, 32'h77170077);
    pulse(3); pulse(2);
    wr(8'h18, 32'h2C); settle();
    expect_rd(8'h10, ent(32'h1000, 2), "R6 fast tie lower index");
    wr(8'h00, 32'h4); settle();
    expect_rd(8'h10, ent(32'h1000, 3), "R6 priority 0 beats 1");
    expect_rd(8'h00, 32'h28, "R5 fast status src3 src5");

    // held level does not re-arm
    @(negedge clk); src[6] = 1'b1; settle();
    expect_rd(8'h08, 32'h40, "R1 edge sets src6");
    wr(8'h08, 32'h40); settle();
    expect_rd(8'h08, 32'h0, "R1 held high no re-set");
    @(negedge clk); src[6] = 1'b0; settle();
    pulse(6); settle();
    expect_rd(8'h08, 32'h40, "R1 new edge sets again");

    // disable all
    wr(8'h18, 32'h0); settle();
    expect_out(1, 0, "R3 fast out disabled");
    expect_out(2, 0, "R3 normal out disabled");
    expect_rd(8'h10, 32'h0, "R3 fast entry cleared by disable");
    expect_rd(8'h00, 32'h28, "R3 status kept while disabled");

    // unmapped offsets
    wr(8'h2C, 32'hFFFFFFFF); wr(8'h28, 32'hFFFFFFFF); wr(8'h50, 32'hFFFFFFFF); settle();
    expect_rd(8'h28, 32'h0, "R11 unmapped read 0x28");
    expect_rd(8'h2C, 32'h0, "R11 unmapped read 0x2C");
    expect_rd(8'h50, 32'h0, "R11 unmapped read 0x50");
    expect_rd(8'h18, 32'h0, "R11 enable untouched");
    expect_rd(8'h24, 32'h1000, "R11 base untouched");
    expect_rd(8'h20, 32'h0, "R11 control untouched");

    // control word
    wr(8'h20, 32'hFFFFFFFF); settle();
    expect_rd(8'h20, 32'h1, "R9 control bit0 only");
    wr(8'h20, 32'h0); settle();
    expect_rd(8'h20, 32'h0, "R9 control written 0");

    // clear everything
    wr(8'h00, 32'hFFFFFFFF); wr(8'h04, 32'hFFFFFFFF);
    wr(8'h08, 32'hFFFFFFFF); wr(8'h0C, 32'hFFFFFFFF); settle();
    expect_rd(8'h00, 32'h0, "R2 all-ones clears fast bank0");
    expect_rd(8'h08, 32'h0, "R2 all-ones clears normal bank0");

    done = 1;
    report();
  end
endmodule